// File: doc/BRIEF.md
# Light Sensor Conversion Sequencer

This block sequences an integrating light-to-frequency converter. A serial interface block hands it command bytes with a one-cycle valid strobe. The converter front end supplies two synchronized pulse streams, one per photodiode: diode 1 sees visible and infrared light, and diode 2 is shielded. A free-running oscillator supplies a one-cycle tick. The block decodes each command into a channel choice (diode 1, diode 2, or the difference of the two), a timing choice, power-down or clear. It counts the pulses of the selected diode over each integration window and counts the oscillator ticks in that window.

There are two timing choices. With self timing, a window closes after a fixed number of oscillator ticks. With command timing, each externally timed command closes the running window and opens the next one. In difference mode the block integrates diode 2 for one window and then diode 1 for a second window. It reports diode 1 minus diode 2 in two's complement. When a conversion ends, the block latches the result and the tick count of the window that just ended, and pulses a done flag for one clock.

Top module: `lux_conv_seq`

## Requirements
- R1: After reset, result_o, cycles_o and done_o are zero. The block stays idle and does not count or latch until it accepts a mode command.
- R2: In a self-timed mode, a window closes on the oscillator tick that brings the window's tick count to WIN_CYCLES. Pulses up to and including that cycle are counted. cycles_o then reads WIN_CYCLES, and the next window starts on the following cycle.
- R3: Mode command codes are decoded as follows. Bits [3:2] select the channel: 0 means diode 1 (pulse_d1_i), 1 means diode 2 (pulse_d2_i), 2 means the difference. Bits [5:4] select the timing: 00 means self-timed, 11 means command-timed. Bits [7:6] and [1:0] must be zero. The valid codes are therefore 0x00, 0x04, 0x08, 0x30, 0x34 and 0x38. In a single-diode mode, pulses on the other diode's input have no effect.
- R4: Difference mode runs a diode 2 window first and a diode 1 window second, with no latch and no done pulse between them. It then latches (d1 − d2) modulo 2^CNT_W as a two's-complement value, and cycles_o holds the tick count of the second window.
- R5: A command-timed mode command, accepted while a command-timed mode is running, closes the running window. The tick and pulse of that same cycle are included in the closed window. The command then opens a new window in the newly commanded mode. A command-timed command accepted while idle or while in a self-timed mode only opens a window.
- R6: The pulse counter and the tick counter both saturate at all ones (2^CNT_W − 1) and do not wrap.
- R7: result_o and cycles_o change only when a conversion completes. done_o is high for exactly the one cycle in which the new values first appear, and is low at all other times.
- R8: Command 0x8C stops counting and clears the running window. While stopped, the block neither latches nor pulses done_o, and the outputs keep their last values. The next valid mode command starts a fresh window.
- R9: Command 0x0C clears both counters and leaves the block idle. The latched outputs are kept.
- R10: Rewriting a mode command, including the one already in force, discards the running window and starts a fresh one.
- R11: Any byte other than the six mode codes, 0x8C and 0x0C is ignored and has no effect on counting, timing or outputs.
- R12: If a command arrives in the same cycle as a self-timed window end, the command takes precedence, and that window is neither latched nor signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Command byte |
| cmd_valid_i | input | 1 | Command strobe, one cycle per byte |
| pulse_d1_i | input | 1 | Converter pulse, diode 1 |
| pulse_d2_i | input | 1 | Converter pulse, diode 2 |
| osc_tick_i | input | 1 | Oscillator tick |
| result_o | output | CNT_W | Latched conversion result |
| cycles_o | output | CNT_W | Tick count of the window that produced result_o |
| done_o | output | 1 | One-cycle flag, high when new values are latched |

## Verification
The bench builds the block with CNT_W = 8 and WIN_CYCLES = 64. A self-timed window then ends within a few dozen cycles, so back-to-back windows, difference pairs and a command colliding with a window end all appear in a short run. Because the counters are only 8 bits wide, both the pulse count and the tick count can be pushed to saturation in a few hundred cycles. Difference results can also be driven negative and checked for wraparound.

// File: rtl/lux_seq_pkg.sv
package lux_seq_pkg;
  typedef enum logic [1:0] {
    CH_D1   = 2'd0,
    CH_D2   = 2'd1,
    CH_DIFF = 2'd2,
    CH_RSVD = 2'd3
  } chan_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_MODE  = 2'd1,
    OP_SLEEP = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  typedef struct packed {
    op_e   op;
    logic  ext;
    chan_e chan;
  } cmd_t;

  localparam logic [7:0] CODE_SLEEP = 8'h8C;
  localparam logic [7:0] CODE_CLEAR = 8'h0C;
endpackage

// File: rtl/lux_cmd_decode.sv
module lux_cmd_decode
  import lux_seq_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  logic timing_ok, chan_ok, frame_ok;

  always_comb begin
    timing_ok = (byte_i[5:4] == 2'b00) || (byte_i[5:4] == 2'b11);
    chan_ok   = (byte_i[3:2] != 2'b11);
    frame_ok  = (byte_i[7:6] == 2'b00) && (byte_i[1:0] == 2'b00);
    cmd_o.ext  = byte_i[5];
    cmd_o.chan = chan_e'(byte_i[3:2]);
    if (byte_i == CODE_SLEEP)                cmd_o.op = OP_SLEEP;
    else if (byte_i == CODE_CLEAR)           cmd_o.op = OP_CLEAR;
    else if (frame_ok && timing_ok && chan_ok) cmd_o.op = OP_MODE;
    else                                     cmd_o.op = OP_NONE;
  end
endmodule

// File: rtl/lux_sat_counter.sv
module lux_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_comb next_o = (inc_i && q_o != MAXV) ? q_o + 1'b1 : q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= next_o;
  end

  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == MAXV && !clr_i) |=> (q_o == MAXV));
endmodule

// File: rtl/lux_conv_ctrl.sv
module lux_conv_ctrl
  import lux_seq_pkg::*;
#(
  parameter int W          = 16,
  parameter int WIN_CYCLES = 32768
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cmd_t         cmd_i,
  input  logic         cmd_valid_i,
  input  logic         pulse_d1_i,
  input  logic         pulse_d2_i,
  input  logic         osc_tick_i,
  input  logic [W-1:0] c_q_i,
  input  logic [W-1:0] p_next_i,
  input  logic [W-1:0] c_next_i,
  output logic         cnt_clr_o,
  output logic         p_inc_o,
  output logic         c_inc_o,
  output logic [W-1:0] result_o,
  output logic [W-1:0] cycles_o,
  output logic         done_o
);
  localparam logic [W-1:0] LAST_TICK = W'(WIN_CYCLES - 1);
  localparam logic [W-1:0] WIN_W     = W'(WIN_CYCLES);

  logic   active_q, ext_q, phase_q;
  chan_e  chan_q;
  logic [W-1:0] hold_q;

  logic cmd_any, is_mode, win_end, close, first_half, fin, sel;

  always_comb begin
    sel        = (chan_q == CH_D1) || (chan_q == CH_DIFF && phase_q) ? pulse_d1_i : pulse_d2_i;
    p_inc_o    = active_q && sel;
    c_inc_o    = active_q && osc_tick_i;
    cmd_any    = cmd_valid_i && (cmd_i.op != OP_NONE);
    is_mode    = cmd_valid_i && (cmd_i.op == OP_MODE);
    win_end    = active_q && !ext_q && osc_tick_i && (c_q_i == LAST_TICK);
    first_half = (chan_q == CH_DIFF) && !phase_q;
    // command wins over a coincident self-timed end
    close      = (is_mode && active_q && ext_q && cmd_i.ext) || (!cmd_any && win_end);
    fin        = close && !first_half;
    cnt_clr_o  = cmd_any || win_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ext_q    <= 1'b0;
      phase_q  <= 1'b0;
      chan_q   <= CH_D1;
      hold_q   <= '0;
      result_o <= '0;
      cycles_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        result_o <= (chan_q == CH_DIFF) ? p_next_i - hold_q : p_next_i;
        cycles_o <= c_next_i;
      end
      if (close && first_half) hold_q <= p_next_i;
      if (cmd_any) begin
        if (is_mode) begin
          active_q <= 1'b1;
          ext_q    <= cmd_i.ext;
          chan_q   <= cmd_i.chan;
          phase_q  <= close && first_half && (cmd_i.chan == CH_DIFF);
        end else begin
          active_q <= 1'b0;
          phase_q  <= 1'b0;
        end
      end else if (win_end) begin
        phase_q <= first_half;
      end
    end
  end

  a_r2_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !ext_q) |-> (c_q_i < WIN_W));
  a_r2_internal_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ext_q) |-> (cycles_o == WIN_W));
  a_r8_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> !done_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(cycles_o)));
  a_r4_no_mid_pair_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close && first_half) |=> !done_o);
endmodule

// File: rtl/lux_conv_seq.sv
module lux_conv_seq
  import lux_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int WIN_CYCLES = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       cmd_i,
  input  logic             cmd_valid_i,
  input  logic             pulse_d1_i,
  input  logic             pulse_d2_i,
  input  logic             osc_tick_i,
  output logic [CNT_W-1:0] result_o,
  output logic [CNT_W-1:0] cycles_o,
  output logic             done_o
);
  cmd_t             cmd;
  logic             clr, p_inc, c_inc;
  logic [CNT_W-1:0] p_q, p_next, c_q, c_next;

  lux_cmd_decode u_dec (
    .byte_i (cmd_i),
    .cmd_o  (cmd)
  );

  lux_sat_counter #(.W(CNT_W)) u_pulse_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (p_inc),
    .q_o    (p_q),
    .next_o (p_next)
  );

  lux_sat_counter #(.W(CNT_W)) u_tick_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (c_inc),
    .q_o    (c_q),
    .next_o (c_next)
  );

  lux_conv_ctrl #(.W(CNT_W), .WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .cmd_valid_i (cmd_valid_i),
    .pulse_d1_i  (pulse_d1_i),
    .pulse_d2_i  (pulse_d2_i),
    .osc_tick_i  (osc_tick_i),
    .c_q_i       (c_q),
    .p_next_i    (p_next),
    .c_next_i    (c_next),
    .cnt_clr_o   (clr),
    .p_inc_o     (p_inc),
    .c_inc_o     (c_inc),
    .result_o    (result_o),
    .cycles_o    (cycles_o),
    .done_o      (done_o)
  );

  a_r6_pulse_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_q == {CNT_W{1'b1}} && !clr) |=> (p_q == {CNT_W{1'b1}}));
endmodule

// File: tb/sim_lux_conv_seq.sv
module sim_lux_conv_seq;
  localparam int W    = 8;
  localparam int WIN  = 64;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   cmd = 8'h00;
  logic         cmd_v = 1'b0, pa = 1'b0, pb = 1'b0, tk = 1'b0;
  logic [W-1:0] res, cyc;
  logic         done;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference state
  bit m_active, m_ext, m_phase, m_done;
  int m_chan, m_p, m_c, m_hold, m_res, m_cyc;

  always #10 clk = ~clk;

  lux_conv_seq #(.CNT_W(W), .WIN_CYCLES(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .cmd_valid_i(cmd_v),
    .pulse_d1_i(pa), .pulse_d2_i(pb), .osc_tick_i(tk),
    .result_o(res), .cycles_o(cyc), .done_o(done));

  function automatic int sat_inc(int v, bit b);
    return (b && v != MAXV) ? v + 1 : v;
  endfunction

  // 0 none, 1 mode, 2 sleep, 3 clear
  function automatic int ref_op(bit v, logic [7:0] b);
    if (!v) return 0;
    if (b == 8'h8C) return 2;
    if (b == 8'h0C) return 3;
    if (b == 8'h00 || b == 8'h04 || b == 8'h08 ||
        b == 8'h30 || b == 8'h34 || b == 8'h38) return 1;
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(bit cv, logic [7:0] cb, bit a, bit b, bit t);
    int pn, cn, op;
    bit sel, first, winend, closing;
    m_done  = 0;
    sel     = (m_chan == 0 || (m_chan == 2 && m_phase)) ? a : b;
    pn      = sat_inc(m_p, m_active && sel);
    cn      = sat_inc(m_c, m_active && t);
    op      = ref_op(cv, cb);
    first   = (m_chan == 2) && !m_phase;
    winend  = m_active && !m_ext && t && (m_c == WIN - 1);
    closing = (op == 1 && m_active && m_ext && cb[5]) || (op == 0 && winend);
    if (closing) begin
      if (first) m_hold = pn;
      else begin
        m_done = 1;
        m_res  = (m_chan == 2) ? ((pn - m_hold) & MAXV) : pn;
        m_cyc  = cn;
      end
    end
    if (op == 1) begin
      m_phase = closing && first && (cb[3:2] == 2);
      m_active = 1; m_ext = cb[5]; m_chan = int'(cb[3:2]); m_p = 0; m_c = 0;
    end else if (op >= 2) begin
      m_active = 0; m_phase = 0; m_p = 0; m_c = 0;
    end else if (winend) begin
      m_phase = first; m_p = 0; m_c = 0;
    end else begin
      m_p = pn; m_c = cn;
    end
  endtask

  task automatic step(bit cv, logic [7:0] cb, bit a, bit b, bit t);
    cmd_v = cv; cmd = cb; pa = a; pb = b; tk = t;
    @(posedge clk);
    model(cv, cb, a, b, t);
    @(negedge clk);
    check(cur_req, "done_o", int'(done), int'(m_done));
    check(cur_req, "result_o", int'(res), m_res);
    check(cur_req, "cycles_o", int'(cyc), m_cyc);
  endtask

  task automatic run(int n, int pa_pct, int pb_pct, int tk_pct);
    for (int i = 0; i < n; i++)
      step(0, 8'h00, $urandom_range(99) < pa_pct, $urandom_range(99) < pb_pct,
           $urandom_range(99) < tk_pct);
  endtask

  task automatic send(logic [7:0] c);
    step(1, c, $urandom_range(1), $urandom_range(1), $urandom_range(1));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] pool [10];
    void'($urandom(32'd4711));
    pool = '{8'h00, 8'h04, 8'h08, 8'h30, 8'h34, 8'h38, 8'h8C, 8'h0C, 8'h3C, 8'hA5};
    m_active = 0; m_ext = 0; m_phase = 0; m_done = 0;
    m_chan = 0; m_p = 0; m_c = 0; m_hold = 0; m_res = 0; m_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, idle without command
    cur_req = "R1";
    check("R1", "result_o", int'(res), 0);
    check("R1", "cycles_o", int'(cyc), 0);
    check("R1", "done_o", int'(done), 0);
    run(150, 50, 50, 100);

    // R2: self-timed diode 1, back-to-back windows
    cur_req = "R2";
    send(8'h00); run(200, 40, 80, 100);
    run(300, 60, 10, 40);

    // R3: diode 2 only, diode 1 activity ignored
    cur_req = "R3";
    send(8'h04); run(200, 90, 20, 100);

    // R4: difference, positive then negative
    cur_req = "R4";
    send(8'h08); run(260, 70, 20, 100);
    send(8'h08); run(260, 10, 60, 100);

    // R5: command-timed windows, single and difference
    cur_req = "R5";
    send(8'h30); run(40, 50, 50, 60);
    send(8'h30); run(25, 50, 50, 60);
    send(8'h34); run(30, 30, 70, 60);
    send(8'h38); run(20, 80, 30, 60);
    send(8'h38); run(20, 80, 30, 60);
    send(8'h38); run(20, 20, 90, 60);
    send(8'h38);
    send(8'h30); send(8'h30);

    // R6: saturation of both counters
    cur_req = "R6";
    send(8'h30); run(300, 100, 0, 100);
    step(1, 8'h30, 1, 0, 1);
    check("R6", "result_o saturated", int'(res), MAXV);
    check("R6", "cycles_o saturated", int'(cyc), MAXV);
    send(8'h00); run(340, 100, 100, 20);

    // R8: power down, then wake
    cur_req = "R8";
    send(8'h00); run(30, 50, 50, 100);
    send(8'h8C); run(200, 100, 100, 100);
    send(8'h04); run(150, 50, 50, 100);

    // R9: clear leaves the block idle with outputs kept
    cur_req = "R9";
    send(8'h30); run(20, 50, 50, 100);
    send(8'h0C); run(100, 100, 100, 100);
    send(8'h30); run(17, 100, 0, 100); send(8'h30);

    // R10: rewrite restarts the window
    cur_req = "R10";
    send(8'h00); run(30, 50, 50, 100);
    step(1, 8'h00, 0, 0, 1);
    n = 0;
    do begin step(0, 8'h00, 1, 0, 1); n++; end while (!done && n < 200);
    check("R10", "steps to done after rewrite", n, WIN);
    check("R10", "result after rewrite", int'(res), WIN);

    // R11: unknown bytes ignored
    cur_req = "R11";
    send(8'h00); run(10, 50, 50, 100);
    foreach (pool[i]) if (i >= 8) begin send(pool[i]); run(5, 50, 50, 100); end
    send(8'h01); send(8'hFF); send(8'h3C); send(8'h40);
    run(120, 50, 50, 100);

    // R12: command in the same cycle as a self-timed end
    cur_req = "R12";
    send(8'h00);
    n = 0;
    while (m_c != WIN - 1 && n < 200) begin step(0, 8'h00, 1, 1, 1); n++; end
    step(1, 8'h04, 1, 1, 1);
    check("R12", "done_o on collision", int'(done), 0);
    run(100, 50, 50, 100);

    // R7: mixed random traffic, outputs held between conversions
    cur_req = "R7";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(39) == 0) send(pool[$urandom_range(9)]);
      else step(0, 8'h00, $urandom_range(1), $urandom_range(2) == 0,
                $urandom_range(3) != 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule